// File: doc/BRIEF.md
# Virtual Processor Block Sequencer

This block is the sequencer in one execution cluster of a lane. It takes one execute directive at a time from a queue. Each directive names an instruction block by its start address, and either one virtual processor or a count of virtual processors. The sequencer reads the block's instructions from an external instruction store, one per cycle, and issues each against the register state of the active virtual processor. It runs a whole block for one virtual processor before it moves on to the next.

A single adder-style datapath and a 32-entry physical register file are shared by all virtual processors on the lane. Configuration inputs split the register file into a shared region and per-processor private regions. The same split sets how many virtual processors fit on the lane. A one-bit predicate register gates thread-fetch instructions, which send a target address back to the fetch manager.

Top module: `vps_seq_top`

## Requirements
- R1: While reset is asserted, `busy`, `dir_pop`, `rf_we`, `tf_valid` and `reg_err` are all low.
- R2: For a vector directive of length L, the block is issued in full for processor 0, then for 1, and so on up to L-1. `cur_vp` holds steady within a block, and `instr_addr` returns to the start address for each new processor.
- R3: A virtual register number v below the shared count S maps to physical index v, whatever processor is active.
- R4: A virtual register number v with S <= v < S+P maps to physical index S + vp*P + (v-S).
- R5: `max_vps` equals floor((32-S)/P). It is 0 when P is 0 or S is 32 or more.
- R6: `dir_pop` is high only in a cycle where the sequencer is idle and `dir_valid` is high. The first instruction of that directive issues in the next cycle. The sequencer goes idle in the cycle after the end-flagged instruction of the last processor.
- R7: A single-processor directive runs the block once for the processor index given in `dir_arg`.
- R8: A vector directive whose length is 0 is popped and issues no instruction.
- R9: An instruction that names a virtual register at or above S+P raises `reg_err` in its issue cycle and writes nothing.
- R10: A private register whose physical index would reach 32 or more, because the processor lies beyond capacity, raises `reg_err` and writes nothing.
- R11: A thread-fetch instruction with the predicate set raises `tf_valid` with the active processor on `tf_vp` and the value of register rs1 on `tf_addr`. With the predicate clear, it raises nothing.
- R12: The predicate resets to 0. A set-predicate instruction loads it with (rs1 value != 0), and the new value is seen by the next instruction.
- R13: The instruction word is laid out as bit 18 end flag, bits 17:15 opcode, 14:10 rd, 9:5 rs1, 4:0 rs2 or immediate. The opcodes are 0 no-op, 1 rd=rs1+rs2, 2 rd=rs1+imm, 3 rd=processor index, 4 set predicate, 5 thread fetch. Results wrap at the data width, and private registers keep their values across directives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shared | input | 6 | Shared register count S |
| cfg_private | input | 6 | Private registers per processor P |
| max_vps | output | VP_W | Processors that fit in the register file |
| dir_valid | input | 1 | A directive is at the head of the queue |
| dir_vector | input | 1 | 1: vector directive, 0: single processor |
| dir_arg | input | VP_W | Vector length, or the processor index |
| dir_addr | input | IA_W | Block start address |
| dir_pop | output | 1 | Head directive consumed this cycle |
| instr_addr | output | IA_W | Instruction store read address |
| instr_data | input | 19 | Instruction word at `instr_addr` |
| busy | output | 1 | An instruction issues this cycle |
| cur_vp | output | VP_W | Active processor |
| rf_we | output | 1 | Register file write this cycle |
| rf_waddr | output | 5 | Physical write index |
| rf_wdata | output | DATA_W | Write data |
| reg_err | output | 1 | Register number out of range this cycle |
| tf_valid | output | 1 | Thread fetch request |
| tf_vp | output | VP_W | Processor that made the request |
| tf_addr | output | IA_W | Requested block address |

## Verification
The bench aims at the edges of the address mapping: the last private slot that still fits (index 31), a processor one past capacity, a register number just at S+P, the case with no private registers, and the case with no shared registers. A wrong mapper would write into another processor's private slot, or wrap into the shared region, instead of flagging an error. On the sequencing side, the bench holds the next directive at the queue head while a vector block runs. A sequencer that pops too early, or restarts the block at the wrong address, would show a pop during the run or the wrong `instr_addr`. A zero-length vector, a predicate left clear since reset, and a predicate changed between two processors in the same block round out the cases. A late predicate update would make the wrong processor's thread fetch fire.

// File: rtl/vps_pkg.sv
package vps_pkg;
  localparam int NREG    = 32;
  localparam int RI_W    = $clog2(NREG);
  localparam int CFG_W   = RI_W + 1;
  localparam int INSTR_W = 1 + 3 + 3 * RI_W;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_ADD    = 3'd1,
    OP_ADDI   = 3'd2,
    OP_LDVP   = 3'd3,
    OP_SETP   = 3'd4,
    OP_TFETCH = 3'd5
  } op_e;

  typedef struct packed {
    logic            eop;
    op_e             op;
    logic [RI_W-1:0] rd;
    logic [RI_W-1:0] rs1;
    logic [RI_W-1:0] rs2;
  } instr_t;
endpackage

// File: rtl/vps_reg_map.sv
module vps_reg_map
  import vps_pkg::*;
#(
  parameter int VP_W = 6
) (
  input  logic [CFG_W-1:0] cfg_shared,
  input  logic [CFG_W-1:0] cfg_private,
  input  logic [VP_W-1:0]  vp,
  input  logic [RI_W-1:0]  vreg,
  output logic [RI_W-1:0]  phys,
  output logic             err
);
  localparam int SUM_W = CFG_W + VP_W + 1;

  logic [SUM_W-1:0] limit;
  logic [SUM_W-1:0] full;

  always_comb begin
    limit = SUM_W'(cfg_shared) + SUM_W'(cfg_private);
    full  = SUM_W'(vreg);
    if (SUM_W'(vreg) >= SUM_W'(cfg_shared)) begin
      full = SUM_W'(cfg_shared) + SUM_W'(vp) * SUM_W'(cfg_private)
           + (SUM_W'(vreg) - SUM_W'(cfg_shared));
    end
    err  = (SUM_W'(vreg) >= limit) || (full >= SUM_W'(NREG));
    phys = err ? '0 : full[RI_W-1:0];
  end
endmodule

// File: rtl/vps_seq_ctrl.sv
module vps_seq_ctrl #(
  parameter int IA_W = 4,
  parameter int VP_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_valid,
  input  logic            dir_vector,
  input  logic [VP_W-1:0] dir_arg,
  input  logic [IA_W-1:0] dir_addr,
  input  logic            instr_eop,
  output logic            dir_pop,
  output logic            issue,
  output logic [VP_W-1:0] vp_q,
  output logic [IA_W-1:0] pc_q
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e             st_q, st_d;
  logic [IA_W-1:0] pc_d, base_q, base_d;
  logic [VP_W-1:0] vp_d, last_q, last_d;
  logic            en;
  logic            zero_len;

  assign zero_len = dir_vector && (dir_arg == '0);

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    base_d  = base_q;
    vp_d    = vp_q;
    last_d  = last_q;
    dir_pop = 1'b0;
    issue   = (st_q == ST_RUN);
    en      = 1'b0;
    if (st_q == ST_IDLE) begin
      if (dir_valid) begin
        dir_pop = 1'b1;
        en      = 1'b1;
        if (!zero_len) begin
          st_d   = ST_RUN;
          pc_d   = dir_addr;
          base_d = dir_addr;
          vp_d   = dir_vector ? '0 : dir_arg;
          last_d = dir_vector ? dir_arg - 1'b1 : dir_arg;
        end
      end
    end else begin
      en = 1'b1;
      if (instr_eop) begin
        if (vp_q == last_q) begin
          st_d = ST_IDLE;
        end else begin
          vp_d = vp_q + 1'b1;
          pc_d = base_q;
        end
      end else begin
        pc_d = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      base_q <= '0;
      vp_q   <= '0;
      last_q <= '0;
    end else if (en) begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      base_q <= base_d;
      vp_q   <= vp_d;
      last_q <= last_d;
    end
  end

  // R6
  pop_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_pop && !zero_len) |=> issue);

  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_pop && zero_len) |=> !issue);

  // R2
  vp_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && instr_eop && vp_q != last_q) |=>
      (issue && vp_q == VP_W'($past(vp_q) + 1'b1) && pc_q == $past(base_q)));

  // R2
  vp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !instr_eop) |=> (issue && $stable(vp_q)));
endmodule

// File: rtl/vps_exec.sv
module vps_exec
  import vps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IA_W   = 4,
  parameter int VP_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  instr_t            instr,
  input  logic [VP_W-1:0]   vp,
  input  logic [2:0][RI_W-1:0] phys,
  input  logic [2:0]        map_err,
  output logic              rf_we,
  output logic [RI_W-1:0]   rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              reg_err,
  output logic              tf_valid,
  output logic [VP_W-1:0]   tf_vp,
  output logic [IA_W-1:0]   tf_addr
);
  logic [DATA_W-1:0] rf_q [NREG];
  logic              pred_q, pred_d, pred_en;
  logic              use_rd, use_s1, use_s2;
  logic [DATA_W-1:0] opa, opb;

  always_comb begin
    use_rd  = (instr.op == OP_ADD) || (instr.op == OP_ADDI) || (instr.op == OP_LDVP);
    use_s1  = (instr.op == OP_ADD) || (instr.op == OP_ADDI) ||
              (instr.op == OP_SETP) || (instr.op == OP_TFETCH);
    use_s2  = (instr.op == OP_ADD);
    reg_err = issue && ((use_rd && map_err[0]) || (use_s1 && map_err[1]) ||
                        (use_s2 && map_err[2]));
    opa     = rf_q[phys[1]];
    opb     = rf_q[phys[2]];
    case (instr.op)
      OP_ADD:  rf_wdata = opa + opb;
      OP_ADDI: rf_wdata = opa + DATA_W'(instr.rs2);
      OP_LDVP: rf_wdata = DATA_W'(vp);
      default: rf_wdata = '0;
    endcase
    rf_we    = issue && use_rd && !reg_err;
    rf_waddr = phys[0];
    pred_en  = issue && (instr.op == OP_SETP) && !reg_err;
    pred_d   = (opa != '0);
    tf_valid = issue && (instr.op == OP_TFETCH) && pred_q && !reg_err;
    tf_vp    = vp;
    tf_addr  = opa[IA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rf_we) begin
      rf_q[rf_waddr] <= rf_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q <= 1'b0;
    end else if (pred_en) begin
      pred_q <= pred_d;
    end
  end

  // R11
  tf_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tf_valid |-> (pred_q && issue));
endmodule

// File: rtl/vps_seq_top.sv
module vps_seq_top
  import vps_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IA_W   = 4,
  parameter int VP_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_shared,
  input  logic [CFG_W-1:0]   cfg_private,
  output logic [VP_W-1:0]    max_vps,
  input  logic               dir_valid,
  input  logic               dir_vector,
  input  logic [VP_W-1:0]    dir_arg,
  input  logic [IA_W-1:0]    dir_addr,
  output logic               dir_pop,
  output logic [IA_W-1:0]    instr_addr,
  input  logic [INSTR_W-1:0] instr_data,
  output logic               busy,
  output logic [VP_W-1:0]    cur_vp,
  output logic               rf_we,
  output logic [RI_W-1:0]    rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               reg_err,
  output logic               tf_valid,
  output logic [VP_W-1:0]    tf_vp,
  output logic [IA_W-1:0]    tf_addr
);
  localparam int PROD_W = CFG_W + VP_W + 1;

  instr_t                instr;
  logic                  issue;
  logic [VP_W-1:0]       vp_q;
  logic [IA_W-1:0]       pc_q;
  logic [2:0][RI_W-1:0]  vregs;
  logic [2:0][RI_W-1:0]  phys;
  logic [2:0]            map_err;
  logic [CFG_W-1:0]      room;

  assign instr      = instr_t'(instr_data);
  assign vregs      = {instr.rs2, instr.rs1, instr.rd};
  assign busy       = issue;
  assign cur_vp     = vp_q;
  assign instr_addr = pc_q;

  always_comb begin
    room    = (cfg_shared >= CFG_W'(NREG)) ? '0 : CFG_W'(NREG) - cfg_shared;
    max_vps = (cfg_private == '0) ? '0 : VP_W'(room / cfg_private);
  end

  vps_seq_ctrl #(.IA_W(IA_W), .VP_W(VP_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .dir_valid(dir_valid), .dir_vector(dir_vector),
    .dir_arg(dir_arg), .dir_addr(dir_addr), .instr_eop(instr.eop),
    .dir_pop(dir_pop), .issue(issue), .vp_q(vp_q), .pc_q(pc_q)
  );

  for (genvar g = 0; g < 3; g++) begin : g_map
    vps_reg_map #(.VP_W(VP_W)) map_i (
      .cfg_shared(cfg_shared), .cfg_private(cfg_private), .vp(vp_q),
      .vreg(vregs[g]), .phys(phys[g]), .err(map_err[g])
    );
  end

  vps_exec #(.DATA_W(DATA_W), .IA_W(IA_W), .VP_W(VP_W)) exec_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .vp(vp_q),
    .phys(phys), .map_err(map_err), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .reg_err(reg_err), .tf_valid(tf_valid),
    .tf_vp(tf_vp), .tf_addr(tf_addr)
  );

  // R5
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_private != '0 && cfg_shared <= CFG_W'(NREG)) |->
      ((PROD_W'(max_vps) * PROD_W'(cfg_private) <= PROD_W'(room)) &&
       ((PROD_W'(max_vps) + 1'b1) * PROD_W'(cfg_private) > PROD_W'(room))));
endmodule

// File: tb/vps_seq_top_tb_top.sv
`timescale 1ns/1ps
module vps_seq_top_tb_top;
  localparam int DATA_W = 16;
  localparam int IA_W   = 4;
  localparam int VP_W   = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [5:0]        cfg_shared, cfg_private;
  logic [VP_W-1:0]   max_vps;
  logic              dir_valid, dir_vector;
  logic [VP_W-1:0]   dir_arg;
  logic [IA_W-1:0]   dir_addr;
  logic              dir_pop;
  logic [IA_W-1:0]   instr_addr;
  logic [18:0]       instr_data;
  logic              busy;
  logic [VP_W-1:0]   cur_vp;
  logic              rf_we;
  logic [4:0]        rf_waddr;
  logic [DATA_W-1:0] rf_wdata;
  logic              reg_err;
  logic              tf_valid;
  logic [VP_W-1:0]   tf_vp;
  logic [IA_W-1:0]   tf_addr;

  logic [18:0] imem [16];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign instr_data = imem[instr_addr];

  vps_seq_top #(.DATA_W(DATA_W), .IA_W(IA_W), .VP_W(VP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared), .cfg_private(cfg_private),
    .max_vps(max_vps), .dir_valid(dir_valid), .dir_vector(dir_vector),
    .dir_arg(dir_arg), .dir_addr(dir_addr), .dir_pop(dir_pop),
    .instr_addr(instr_addr), .instr_data(instr_data), .busy(busy),
    .cur_vp(cur_vp), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .reg_err(reg_err), .tf_valid(tf_valid), .tf_vp(tf_vp), .tf_addr(tf_addr)
  );

  // entry: S, P, vp, vreg, expected max_vps, expected phys, expected error
  localparam logic [34:0] MAP_TBL [11] = '{
    {6'd4,  6'd4,  6'd0, 5'd4,  6'd7, 5'd4,  1'b0},  // R4 first private slot
    {6'd4,  6'd4,  6'd2, 5'd6,  6'd7, 5'd14, 1'b0},  // R4
    {6'd4,  6'd4,  6'd6, 5'd7,  6'd7, 5'd31, 1'b0},  // R4 last slot
    {6'd4,  6'd4,  6'd7, 5'd4,  6'd7, 5'd0,  1'b1},  // R10 beyond capacity
    {6'd4,  6'd4,  6'd1, 5'd8,  6'd7, 5'd0,  1'b1},  // R9 at S+P
    {6'd8,  6'd3,  6'd3, 5'd2,  6'd8, 5'd2,  1'b0},  // R3 shared
    {6'd0,  6'd8,  6'd3, 5'd5,  6'd4, 5'd29, 1'b0},  // R4 no shared
    {6'd2,  6'd5,  6'd5, 5'd6,  6'd6, 5'd31, 1'b0},  // R4
    {6'd32, 6'd1,  6'd0, 5'd31, 6'd0, 5'd31, 1'b0},  // R3 all shared, R5 zero
    {6'd5,  6'd0,  6'd0, 5'd5,  6'd0, 5'd0,  1'b1},  // R9 no private, R5 zero
    {6'd1,  6'd31, 6'd0, 5'd31, 6'd1, 5'd31, 1'b0}   // R4 single processor
  };

  function automatic logic [18:0] mk(input logic eop, input logic [2:0] op,
      input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2);
    return {eop, op, rd, rs1, rs2};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_dir(input logic vec, input logic [VP_W-1:0] arg,
                          input logic [IA_W-1:0] addr);
    @(negedge clk);
    dir_vector = vec; dir_arg = arg; dir_addr = addr; dir_valid = 1'b1;
    @(posedge clk);
    #1 dir_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) imem[i] = '0;
    rst_n = 1'b0; dir_valid = 1'b0; dir_vector = 1'b0; dir_arg = '0; dir_addr = '0;
    cfg_shared = 6'd4; cfg_private = 6'd4;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(dir_pop == 1'b0, "R1", "dir_pop", dir_pop, 0);
    chk(rf_we == 1'b0, "R1", "rf_we", rf_we, 0);
    chk(tf_valid == 1'b0, "R1", "tf_valid", tf_valid, 0);
    chk(reg_err == 1'b0, "R1", "reg_err", reg_err, 0);
    rst_n = 1'b1;

    // R12 predicate clear after reset: thread fetch stays silent
    imem[14] = mk(1'b1, 3'd5, 5'd0, 5'd0, 5'd0);
    send_dir(1'b0, 6'd0, 4'd14);
    chk(busy == 1'b1, "R12", "busy", busy, 1);
    chk(tf_valid == 1'b0, "R12", "tf_valid", tf_valid, 0);

    // table of mapping cases: R3 R4 R5 R7 R9 R10
    for (int t = 0; t < 11; t++) begin
      logic [34:0] e;
      e = MAP_TBL[t];
      @(negedge clk);
      cfg_shared = e[34:29]; cfg_private = e[28:23];
      imem[0] = mk(1'b1, 3'd3, e[16:12], 5'd0, 5'd0);
      send_dir(1'b0, e[22:17], 4'd0);
      chk(max_vps == e[11:6], "R5", "max_vps", max_vps, e[11:6]);
      chk(cur_vp == e[22:17], "R7", "cur_vp", cur_vp, e[22:17]);
      chk(reg_err == e[0], "R9/R10", "reg_err", reg_err, e[0]);
      chk(rf_we == !e[0], "R9/R10", "rf_we", rf_we, !e[0]);
      if (!e[0]) begin
        chk(rf_waddr == e[5:1], "R3/R4", "rf_waddr", rf_waddr, e[5:1]);
        chk(rf_wdata == DATA_W'(e[22:17]), "R13", "ldvp data", rf_wdata, e[22:17]);
      end
    end

    // vector run of length 3 with the next directive waiting: R2 R6 R13
    @(negedge clk);
    cfg_shared = 6'd4; cfg_private = 6'd4;
    imem[4] = mk(1'b0, 3'd3, 5'd4, 5'd0, 5'd0);
    imem[5] = mk(1'b1, 3'd2, 5'd5, 5'd4, 5'd10);
    imem[8] = mk(1'b1, 3'd1, 5'd6, 5'd4, 5'd5);
    dir_vector = 1'b1; dir_arg = 6'd3; dir_addr = 4'd4; dir_valid = 1'b1;
    #1 chk(dir_pop == 1'b1, "R6", "pop when idle", dir_pop, 1);
    @(posedge clk);
    #1 dir_vector = 1'b0; dir_arg = 6'd1; dir_addr = 4'd8;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R2", "busy", busy, 1);
      chk(cur_vp == k / 2, "R2", "cur_vp", cur_vp, k / 2);
      chk(instr_addr == 4 + k % 2, "R2", "instr_addr", instr_addr, 4 + k % 2);
      chk(dir_pop == 1'b0, "R6", "no pop while running", dir_pop, 0);
      chk(rf_waddr == 4 + (k / 2) * 4 + k % 2, "R4", "rf_waddr", rf_waddr,
          4 + (k / 2) * 4 + k % 2);
      chk(rf_wdata == ((k % 2) ? k / 2 + 10 : k / 2), "R13", "rf_wdata", rf_wdata,
          (k % 2) ? k / 2 + 10 : k / 2);
    end
    @(negedge clk);
    chk(busy == 1'b0, "R6", "idle after last block", busy, 0);
    chk(dir_pop == 1'b1, "R6", "pop next directive", dir_pop, 1);
    @(posedge clk);
    #1 dir_valid = 1'b0;
    @(negedge clk);
    // R7 single processor 1; R13 private values kept across directives
    chk(cur_vp == 6'd1, "R7", "cur_vp", cur_vp, 1);
    chk(rf_waddr == 5'd10, "R7", "rf_waddr", rf_waddr, 10);
    chk(rf_wdata == 16'd12, "R13", "persisted sum", rf_wdata, 12);
    @(negedge clk);
    chk(busy == 1'b0, "R6", "idle after single", busy, 0);

    // R8 zero-length vector
    @(negedge clk);
    dir_vector = 1'b1; dir_arg = 6'd0; dir_addr = 4'd4; dir_valid = 1'b1;
    #1 chk(dir_pop == 1'b1, "R8", "zero length popped", dir_pop, 1);
    @(posedge clk);
    #1 dir_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "no issue", busy, 0);
    chk(rf_we == 1'b0, "R8", "no write", rf_we, 0);

    // R11 R12 predicate changes between processors
    imem[12] = mk(1'b0, 3'd4, 5'd0, 5'd4, 5'd0);
    imem[13] = mk(1'b1, 3'd5, 5'd0, 5'd5, 5'd0);
    send_dir(1'b1, 6'd2, 4'd12);
    chk(tf_valid == 1'b0, "R12", "setp no fetch", tf_valid, 0);
    @(negedge clk);
    chk(tf_valid == 1'b0, "R11", "pred clear vp0", tf_valid, 0);
    @(negedge clk);
    chk(tf_valid == 1'b0, "R12", "setp vp1", tf_valid, 0);
    @(negedge clk);
    chk(tf_valid == 1'b1, "R11", "pred set vp1", tf_valid, 1);
    chk(tf_vp == 6'd1, "R11", "tf_vp", tf_vp, 1);
    chk(tf_addr == 4'd11, "R11", "tf_addr", tf_addr, 11);
    @(negedge clk);
    chk(busy == 1'b0, "R6", "idle at end", busy, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule